// File: doc/BRIEF.md
# Time-Slot PCM Voice Serial Port

This block moves voice samples between a codec datapath and a framed serial line. Each frame is marked by a frame-sync pulse and is divided into slots of eight bit-clock periods. In its assigned transmit slot the block drives one byte onto the serial output, most significant bit first. In all other periods the enable that controls the output's tristate buffer is low. In its assigned receive slot it shifts in one byte from the serial input. When the byte is complete it hands the byte to the datapath with a one-cycle strobe.

The bit clock, frame sync and receive pin are oversampled by a fast system clock through a parameterised synchroniser. Edges of the bit clock are detected in the system-clock domain. A two-bit timing mode chooses two things: whether slot 0 starts in the same bit period as the frame sync or one period later, and which bit-clock edge launches data and which one captures it. The datapath writes the next transmit byte into a holding register at any time before the slot begins. Transmit and receive slot numbers are separate inputs.

Top module: `pcm_voice_port`

## Requirements
- R1: `tx_drive` is 0 after reset, before the first frame sync, and in every bit period that is not in the assigned transmit slot. `tx_pin` carries data only while `tx_drive` is 1.
- R2: A slot carries 8 bits, one per bit-clock period, sent and received most significant bit first.
- R3: In timing modes 0 and 1 transmit bits are launched on the rising bit-clock edge. In mode 2 they are launched on the falling edge.
- R4: In timing modes 0 and 1 receive bits are captured on the falling bit-clock edge. In mode 2 they are captured on the rising edge.
- R5: Frame sync is sampled at the launch edge. In mode 0 (delayed), bit 0 of slot 0 is the bit period after the one in which sync is seen. In modes 1 and 2 it is the same period.
- R6: Slot n covers bit periods 8n to 8n+7 counted from the frame start. `tx_slot_sel` and `rx_slot_sel` are independent, and periods past the last slot are idle.
- R7: The transmitted byte is the value last written by a `tx_wr` pulse. It is copied from the holding register at the first bit of the transmit slot, and `tx_wdata` without `tx_wr` has no effect.
- R8: After the 8th receive bit of the receive slot is captured, `rx_rdata` holds the byte and `rx_strobe` is high for exactly one system clock. There is one strobe per receive slot.
- R9: Levels on `rx_pin` outside the assigned receive slot do not change `rx_rdata` and cause no strobe.
- R10: A frame sync seen in the middle of a frame restarts bit counting at the new frame. A partial receive byte is dropped without a strobe, and `tx_drive` stays 0 until the next assigned transmit slot, which then sends a whole byte.
- R11: Mode value 3 behaves exactly like mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial signals |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk | input | 1 | Serial bit clock |
| frame_sync | input | 1 | Frame start marker, sampled at the launch edge |
| rx_pin | input | 1 | Serial receive data |
| fs_mode | input | 2 | 0 delayed, 1 non-delayed, 2 non-delayed with swapped edges, 3 as 1 |
| tx_slot_sel | input | SLOT_W | Transmit slot number |
| rx_slot_sel | input | SLOT_W | Receive slot number |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | 8 | Transmit byte |
| tx_pin | output | 1 | Serial transmit data |
| tx_drive | output | 1 | Output-buffer enable for tx_pin (0 means high impedance) |
| rx_strobe | output | 1 | One-cycle pulse when a received byte is ready |
| rx_rdata | output | 8 | Last complete received byte |

## Verification
The sharpest collision is a frame sync that arrives while both the transmit and the receive slot are part-way through a byte. In that case the counter restart, the transmit shift and the receive shift all act at the same launch edge. The bench provokes it in both a non-delayed and a delayed frame by raising sync again inside slot 1, where both directions are assigned. It then judges the result bit period by bit period: the transmit enable must drop at once and the whole byte must be sent again in the new slot 1. Exactly one receive strobe must follow, and it must carry the byte sent after the restart and not the one that was cut off.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
   localparam int BYTE_W = 8;
   localparam int BIT_W  = 3;

   typedef enum logic [1:0] {
      FS_LATE      = 2'd0,
      FS_EARLY     = 2'd1,
      FS_EARLY_INV = 2'd2,
      FS_SPARE     = 2'd3
   } fs_mode_e;
endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] st [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
         end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
         end
      end
      assign q = st[STAGES-1];
   end
endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
   import pcm_port_pkg::*;
#(
   parameter int SLOTS = 4,
   localparam int NBITS = SLOTS * BYTE_W,
   localparam int CW    = $clog2(NBITS + 2)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bclk_s,
   input  logic            fs_s,
   input  logic [1:0]      mode,
   output logic            period_start,
   output logic            capture,
   output logic            in_frame,
   output logic [CW-4:0]   slot,
   output logic [BIT_W-1:0] bitn
);
   logic          bclk_q, run, launch, reverse, late;
   logic [CW-1:0] cnt, idx;

   assign reverse = (fs_mode_e'(mode) == FS_EARLY_INV);
   assign late    = (fs_mode_e'(mode) == FS_LATE);
   // R3 R4: edge roles swap in the reverse mode
   assign launch  = reverse ? (~bclk_s & bclk_q) : (bclk_s & ~bclk_q);
   assign capture = reverse ? (bclk_s & ~bclk_q) : (~bclk_s & bclk_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q       <= 1'b0;
         run          <= 1'b0;
         cnt          <= '0;
         period_start <= 1'b0;
      end else begin
         bclk_q       <= bclk_s;
         period_start <= launch;
         if (launch) begin
            if (fs_s) begin
               // R5 R10: restart on every sync
               run <= 1'b1;
               cnt <= late ? CW'(0) : CW'(1);
            end else if (run && cnt != CW'(NBITS + 1)) begin
               cnt <= cnt + CW'(1);
            end
         end
      end
   end

   assign idx      = cnt - CW'(1);
   assign in_frame = (cnt != '0) && (cnt <= CW'(NBITS));
   assign slot     = idx[CW-1:BIT_W];
   assign bitn     = idx[BIT_W-1:0];

   // R6
   cnt_moves_on_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !launch |=> $stable(cnt));
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
   import pcm_port_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              period_start,
   input  logic              in_slot,
   input  logic              first_bit,
   input  logic              wr,
   input  logic [BYTE_W-1:0] wdata,
   output logic              pin,
   output logic              drive
);
   logic [BYTE_W-1:0] hold, sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold  <= '0;
         sr    <= '0;
         pin   <= 1'b0;
         drive <= 1'b0;
      end else begin
         if (wr) hold <= wdata;
         if (period_start) begin
            drive <= in_slot;
            if (in_slot && first_bit) begin
               sr  <= hold;
               pin <= hold[BYTE_W-1];
            end else if (in_slot) begin
               sr  <= sr << 1;
               pin <= sr[BYTE_W-2];
            end else begin
               pin <= 1'b0;
            end
         end
      end
   end

   // R1
   tx_hold_between_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !period_start |=> $stable({pin, drive}));
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
   import pcm_port_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              in_slot,
   input  logic              last_bit,
   input  logic              rx_s,
   output logic              strobe,
   output logic [BYTE_W-1:0] data
);
   logic [BYTE_W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr     <= '0;
         data   <= '0;
         strobe <= 1'b0;
      end else begin
         strobe <= 1'b0;
         if (capture && in_slot) begin
            sr <= {sr[BYTE_W-2:0], rx_s};
            if (last_bit) begin
               data   <= {sr[BYTE_W-2:0], rx_s};
               strobe <= 1'b1;
            end
         end
      end
   end

   // R8
   rx_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);
   // R8
   rx_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> $past(capture));
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
   import pcm_port_pkg::*;
#(
   parameter int SLOTS       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int SLOT_W      = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_clk,
   input  logic              frame_sync,
   input  logic              rx_pin,
   input  logic [1:0]        fs_mode,
   input  logic [SLOT_W-1:0] tx_slot_sel,
   input  logic [SLOT_W-1:0] rx_slot_sel,
   input  logic              tx_wr,
   input  logic [7:0]        tx_wdata,
   output logic              tx_pin,
   output logic              tx_drive,
   output logic              rx_strobe,
   output logic [7:0]        rx_rdata
);
   localparam int NBITS = SLOTS * BYTE_W;
   localparam int CW    = $clog2(NBITS + 2);

   if (SLOTS < 1 || SLOTS > 64) begin : g_bad_slots
      $error("SLOTS out of range");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES out of range");
   end

   logic [2:0]       raw, syn;
   logic             period_start, capture, in_frame, tx_in, rx_in;
   logic [CW-4:0]    slot;
   logic [BIT_W-1:0] bitn;

   assign raw = {bit_clk, frame_sync, rx_pin};

   pcm_in_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(syn));

   pcm_frame_timer #(.SLOTS(SLOTS)) u_timer (
      .clk(clk), .rst_n(rst_n), .bclk_s(syn[2]), .fs_s(syn[1]), .mode(fs_mode),
      .period_start(period_start), .capture(capture), .in_frame(in_frame),
      .slot(slot), .bitn(bitn));

   // R6: independent slot matches
   assign tx_in = in_frame && (int'(slot) == int'(tx_slot_sel));
   assign rx_in = in_frame && (int'(slot) == int'(rx_slot_sel));

   pcm_tx_lane u_tx (
      .clk(clk), .rst_n(rst_n), .period_start(period_start), .in_slot(tx_in),
      .first_bit(bitn == BIT_W'(0)), .wr(tx_wr), .wdata(tx_wdata),
      .pin(tx_pin), .drive(tx_drive));

   pcm_rx_lane u_rx (
      .clk(clk), .rst_n(rst_n), .capture(capture), .in_slot(rx_in),
      .last_bit(bitn == BIT_W'(BYTE_W - 1)), .rx_s(syn[0]),
      .strobe(rx_strobe), .data(rx_rdata));
endmodule

// File: tb/pcm_voice_port_tb.sv
`timescale 1ns/1ps
module pcm_voice_port_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_clk = 1'b0, frame_sync = 1'b0, rx_pin = 1'b0;
   logic [1:0] fs_mode = 2'd1;
   logic [1:0] tx_slot_sel = '0, rx_slot_sel = '0;
   logic       tx_wr = 1'b0;
   logic [7:0] tx_wdata = '0;
   logic       tx_pin, tx_drive, rx_strobe;
   logic [7:0] rx_rdata;

   int total = 0, bad = 0, pulses = 0, doubles = 0;
   logic last_strobe = 1'b0;

   always #2 clk = ~clk;

   pcm_voice_port u_dut (
      .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .frame_sync(frame_sync),
      .rx_pin(rx_pin), .fs_mode(fs_mode), .tx_slot_sel(tx_slot_sel),
      .rx_slot_sel(rx_slot_sel), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
      .tx_pin(tx_pin), .tx_drive(tx_drive), .rx_strobe(rx_strobe),
      .rx_rdata(rx_rdata));

   always @(negedge clk) begin
      if (rx_strobe) pulses++;
      if (rx_strobe && last_strobe) doubles++;
      last_strobe = rx_strobe;
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   typedef struct packed {
      logic [1:0] mode;
      logic [1:0] txs;
      logic [1:0] rxs;
      logic [7:0] txb;
      logic [7:0] rxb;
      logic [5:0] fs2;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 2'd0, 2'd0, 8'hA5, 8'h3C, 6'd0},
      '{2'd1, 2'd2, 2'd1, 8'h96, 8'hC3, 6'd0},
      '{2'd2, 2'd3, 2'd3, 8'h81, 8'h7E, 6'd0},
      '{2'd2, 2'd1, 2'd0, 8'h5A, 8'hE7, 6'd0},
      '{2'd3, 2'd1, 2'd2, 8'h0F, 8'hF0, 6'd0},
      '{2'd1, 2'd1, 2'd1, 8'h6B, 8'hD4, 6'd11},
      '{2'd0, 2'd1, 2'd1, 8'h39, 8'h9C, 6'd10}
   };
   localparam int NPER = 48;

   task automatic run_frame(input vec_t v);
      logic lvl;
      int   d, p0;
      lvl = (v.mode == 2'd2) ? 1'b0 : 1'b1;
      d   = (v.mode == 2'd0) ? 1 : 0;
      @(negedge clk);
      fs_mode = v.mode; tx_slot_sel = v.txs; rx_slot_sel = v.rxs;
      bit_clk = ~lvl; tx_wdata = v.txb; tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0; tx_wdata = ~v.txb;      // R7: unwritten data must not leak
      repeat (6) @(negedge clk);
      p0 = pulses;
      for (int k = 0; k < NPER; k++) begin
         int kf, idx;
         logic ins_tx, ins_rx;
         string tag;
         kf  = (v.fs2 != 0 && k >= int'(v.fs2)) ? int'(v.fs2) : 0;
         idx = k - kf - d;
         ins_tx = (idx >= 0 && idx < 32 && idx / 8 == int'(v.txs));
         ins_rx = (idx >= 0 && idx < 32 && idx / 8 == int'(v.rxs));
         @(negedge clk);
         bit_clk    = lvl;
         frame_sync = (k == 0) || (v.fs2 != 0 && k == int'(v.fs2));
         rx_pin     = ins_rx ? v.rxb[7 - idx % 8] : (k[0] ^ k[1]);
         repeat (5) @(negedge clk);
         if (v.fs2 != 0) tag = "R10 tx";
         else if (v.mode == 2'd3) tag = "R11 tx";
         else if (ins_tx) tag = "R2 R3 R5 R6 R7 tx";
         else tag = "R1 R5 R6 tx_drive";
         chk(tag, int'(tx_drive), int'(ins_tx));
         if (ins_tx) chk(tag, int'(tx_pin), int'(v.txb[7 - idx % 8]));
         repeat (2) @(negedge clk);
         bit_clk = ~lvl;
         repeat (8) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      // R4 R8 R9: byte from the slot only, one strobe
      chk((v.fs2 != 0) ? "R10 rx_rdata" : "R4 R8 R9 rx_rdata", int'(rx_rdata), int'(v.rxb));
      chk("R8 strobe count", pulses - p0, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      // R1: reset state
      chk("R1 reset drive", int'(tx_drive), 0);
      chk("R8 reset strobe", int'(rx_strobe), 0);
      chk("R8 reset rdata", int'(rx_rdata), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R1 R9: clocks without any frame sync: no drive, no strobe
      for (int k = 0; k < 12; k++) begin
         @(negedge clk); bit_clk = 1'b1; rx_pin = k[0];
         repeat (5) @(negedge clk);
         chk("R1 idle drive", int'(tx_drive), 0);
         repeat (2) @(negedge clk); bit_clk = 1'b0;
         repeat (8) @(negedge clk);
      end
      chk("R9 idle strobes", pulses, 0);
      chk("R9 idle rdata", int'(rx_rdata), 0);
      for (int i = 0; i < NV; i++) run_frame(VECS[i]);
      chk("R8 single-cycle strobe", doubles, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule